// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined Synchronous SRAM

This block produces the word address used inside a synchronous burst SRAM on each cycle of a four-beat burst. A cycle controller issues a load pulse with an external start address. The sequencer holds the upper address field fixed and steps only the two lowest bits, once for each cycle in which the active-low advance input is low. When advance is high, the address stays where it is, which gives a wait state.

Two orderings are available. Linear ordering counts up modulo four from the start value. Interleaved ordering forms each beat's low bits as the XOR of the start low bits and a two-bit beat count. The order select is a static strap. It is captured together with the start address, so the burst in progress keeps its ordering until the next load. After four beats the sequence returns to the start address, and it goes on stepping while advance remains low.

A new load always restarts the sequence from the new address, even in the middle of a burst. A load also wins over an advance requested in the same cycle. Deciding when a load may occur, including strobe and chip-enable qualification, is the job of the cycle controller.

Top module: `burst_addr_gen`

## Requirements
- R1: From the cycle after a load until the next load or reset, addr_o[18:2] equals bits 18:2 of the loaded address.
- R2: With mode_i = 0 at load (linear), after n advance steps addr_o[1:0] = (start[1:0] + n) mod 4.
- R3: With mode_i = 1 at load (interleaved), after n advance steps addr_o[1:0] = start[1:0] XOR (n mod 4).
- R4: After four advance steps addr_o returns to the loaded start address, and further advance steps repeat the same sequence.
- R5: In a cycle with load_i = 0 and adv_n_i = 1, addr_o does not change at the next edge.
- R6: A load makes addr_o equal base_addr_i in the following cycle, whatever the state of a burst in progress, and restarts the beat count.
- R7: When load_i = 1 and adv_n_i = 0 in the same cycle, the load wins: addr_o equals the new base with no step applied.
- R8: The ordering is taken from mode_i at load. A change of mode_i between loads does not alter the sequence of the current burst.
- R9: A synchronous reset (rst = 1) forces addr_o to zero at the next edge and clears the beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load the start address and ordering; restarts the burst |
| base_addr_i | input | 19 | External start address |
| adv_n_i | input | 1 | Active-low advance to the next burst address |
| mode_i | input | 1 | Ordering select: 0 linear, 1 interleaved |
| addr_o | output | 19 | Current internal burst address |

## Verification
The bench builds the block with its default parameters: a 19-bit address with a 2-bit sequenced field. Because that field is so small, the bench can sweep every start value under both orderings and run each burst through more than two full wraps, with wait states inserted in between. The bench also covers a reload in mid-burst, a load that coincides with an advance, a change of the order select during a burst, and a reset applied during a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  localparam int unsigned DEF_ADDR_W = 19;
  localparam int unsigned DEF_BEAT_W = 2;

endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  order_e            order_in,
  output logic [ADDR_W-1:0] base_q,
  output order_e            order_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load) begin
      base_q  <= addr_in;
      order_q <= order_in;
    end
  end

  p_keep_base_r1: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));

  p_keep_order_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(order_q));

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int unsigned BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);

  localparam logic [BEAT_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) beat_q <= '0;
    else if (step)  beat_q <= beat_q + 1'b1;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> $stable(beat_q));

  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr && step && beat_q == LAST) |=> beat_q == '0);

  p_clr_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> beat_q == '0);

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_pkg::*;
#(
  parameter int unsigned BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] lo
);

  function automatic logic [BEAT_W-1:0] f_linear(input logic [BEAT_W-1:0] s,
                                                 input logic [BEAT_W-1:0] k);
    return s + k;
  endfunction

  function automatic logic [BEAT_W-1:0] f_xor(input logic [BEAT_W-1:0] s,
                                              input logic [BEAT_W-1:0] k);
    return s ^ k;
  endfunction

  always_comb begin
    unique case (order)
      ORD_XOR:    lo = f_xor(start_lo, beat);
      default:    lo = f_linear(start_lo, beat);
    endcase
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned BEAT_W = DEF_BEAT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              adv_n_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  // named events for the checks
  logic load_evt, step_evt, wait_evt;
  assign load_evt = load_i;
  assign step_evt = !load_i && !adv_n_i;
  assign wait_evt = !load_i && adv_n_i;

  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] lo;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .load     (load_evt),
    .addr_in  (base_addr_i),
    .order_in (order_e'(mode_i)),
    .base_q   (base_q),
    .order_q  (order_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .clr    (load_evt),
    .step   (step_evt),
    .beat_q (beat_q)
  );

  burst_seq_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo (base_q[BEAT_W-1:0]),
    .beat     (beat_q),
    .order    (order_q),
    .lo       (lo)
  );

  generate
    if (HI_W > 0) begin : g_split
      assign addr_o = {base_q[ADDR_W-1:BEAT_W], lo};
    end else begin : g_low_only
      assign addr_o = lo;
    end
  endgenerate

  p_upper_r1: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  p_wait_r5: assert property (@(posedge clk) disable iff (rst)
    wait_evt |=> $stable(addr_o));

  p_first_r6: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> addr_o == $past(base_addr_i));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> addr_o == '0);

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_i = 1'b0;
  logic [AW-1:0] base_addr_i = '0;
  logic          adv_n_i = 1'b1;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .base_addr_i(base_addr_i),
    .adv_n_i(adv_n_i), .mode_i(mode_i), .addr_o(addr_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected low bits, worked out from the ordering rules
  function automatic logic [1:0] exp_lo(input bit ileave, input int s, input int n);
    int k = n % 4;
    if (ileave) return 2'((s & 2) ^ (k & 2)) | 2'((s & 1) ^ (k & 1));
    return 2'((s + k) % 4);
  endfunction

  task automatic do_load(input logic [AW-1:0] a, input bit m, input bit adv_low);
    load_i = 1'b1; base_addr_i = a; mode_i = m; adv_n_i = !adv_low;
    tick();
    load_i = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    check("R9 reset state", addr_o, '0);
    rst = 1'b0;

    // sweep both orders and every start value, with wait states
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a;
        int n;
        a = {17'(17'h1A5C3 ^ (s * 17'h0421) ^ (m * 17'h10000)), 2'(s)};
        do_load(a, m[0], 1'b1);      // advance low in the load cycle: R7
        check("R7 load beats advance", addr_o, a);
        n = 0;
        for (int c = 0; c < 12; c++) begin
          bit hold;
          hold = (c % 5 == 3);
          adv_n_i = hold;
          tick();
          if (!hold) n++;
          if (hold)
            check("R5 wait holds", addr_o, {a[AW-1:2], exp_lo(m[0], s, n)});
          else if (n % 4 == 0)
            check("R4 wrap to start", addr_o, a);
          else if (m == 0)
            check("R2 linear", addr_o, {a[AW-1:2], exp_lo(1'b0, s, n)});
          else
            check("R3 interleaved", addr_o, {a[AW-1:2], exp_lo(1'b1, s, n)});
          check("R1 upper held", {addr_o[AW-1:2], 2'b00}, {a[AW-1:2], 2'b00});
        end
        adv_n_i = 1'b1;
      end
    end

    // reload in mid-burst
    do_load(19'h2_3457, 1'b1, 1'b0);
    adv_n_i = 1'b0; tick(); tick();
    do_load(19'h5_0002, 1'b1, 1'b0);
    check("R6 reload mid-burst", addr_o, 19'h5_0002);
    adv_n_i = 1'b0; tick();
    check("R6 restart count", addr_o, 19'h5_0003);

    // order select changes during a burst
    do_load(19'h0_7771, 1'b0, 1'b0);
    mode_i = 1'b1;
    adv_n_i = 1'b0; tick();
    check("R8 mode change ignored", addr_o, 19'h0_7772);
    tick();
    check("R8 mode change ignored", addr_o, 19'h0_7773);
    tick();
    check("R8 mode change ignored", addr_o, 19'h0_7770);

    // reset in mid-burst
    rst = 1'b1; tick();
    check("R9 reset mid-burst", addr_o, '0);
    rst = 1'b0; adv_n_i = 1'b0; tick();
    check("R9 count cleared, linear after reset", addr_o, 19'h0_0001);
    adv_n_i = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule